// File: doc/BRIEF.md
# FIFO Drain-to-RAM Controller

This block sits on the read side of a FIFO. It empties the FIFO one word at a time and stores the words at consecutive locations of a small single-port RAM, which is included in the block. While the FIFO is empty the block waits. Each word takes a two-cycle handshake: a fetch cycle and a store cycle. In the fetch cycle the block requests a read and moves the RAM pointer forward. In the store cycle it writes the returned word, starts a read of that location and counts the word.

The FIFO side is plain control with no back-pressure. The controller pulls a word only when the empty flag is low, and it expects the word one cycle after its request, as a FIFO in normal (non look-ahead) mode provides. The RAM pointer rests at all-ones after reset, so the first pre-increment stores the first word at location zero. Returning to the waiting state keeps the pointer where it is, so later words go on at the next location. Only the synchronous reset rewinds the pointer and clears the count.

Top module: `fifo_drain_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, the block is reset at that edge: after the edge `st_addr` is all-ones, `xfer_count` is zero, `st_q` is zero, and `src_rd_req`, `st_we` and `st_re` are low.
- R2: While the controller waits and `fifo_empty` is high, it issues no read request and `st_addr` does not change, whatever the reset level was before.
- R3: In a cycle where the controller waits and `fifo_empty` is low, the next cycle is a fetch cycle. In a fetch cycle `src_rd_req` is high and `st_addr` is one more than before, modulo 2^ADDR_W.
- R4: Every fetch cycle is followed by exactly one store cycle. In a store cycle `st_we` and `st_re` are high and `src_rd_req` is low. A request therefore lasts exactly one cycle per word.
- R5: In a store cycle `st_wdata` equals the FIFO word returned for the preceding request, and `st_addr` keeps its fetch-cycle value.
- R6: `xfer_count` goes up by one on entry to each store cycle, so its value during the store cycle includes the word being stored.
- R7: In the cycle after a store cycle, `st_q` shows the word just stored.
- R8: After a store cycle, the next cycle is a fetch cycle if `fifo_empty` is low, and the controller waits if it is high. A continuous stream therefore moves one word every two cycles.
- R9: A wait between words keeps `st_addr`. The next word goes to the following location.
- R10: The pointer wraps from all-ones to zero, and the word at location zero is overwritten by the word stored there later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| fifo_empty | input | 1 | FIFO empty flag |
| src_rd_req | output | 1 | FIFO read request, one cycle per word |
| src_data | input | DATA_W | FIFO read data, valid one cycle after the request |
| st_addr | output | ADDR_W | RAM address |
| st_wdata | output | DATA_W | RAM write data |
| st_we | output | 1 | RAM write enable |
| st_re | output | 1 | RAM read enable |
| st_q | output | DATA_W | RAM read data |
| xfer_count | output | CNT_W | Number of words stored since reset |

## Verification
On every cycle, the assertions check how requests and stores alternate: each request is followed by a store, and a request never lasts two cycles. They also check the pointer step on each fetch, the steady address during a store, the counter step, that a store chains straight into a fetch when data remains, and that RAM output follows each store. Some behaviour only the directed scenarios can show. These are: the exact data that lands at each address across single words, bursts and a pointer wrap; that the pointer is kept across idle gaps; and that a later reset rewinds the pointer so the next word lands at zero.

// File: rtl/drain_pkg.sv
package drain_pkg;
  typedef enum logic [1:0] {
    ST_PARK  = 2'd0,
    ST_FETCH = 2'd1,
    ST_STORE = 2'd2
  } drain_state_e;
endpackage

// File: rtl/drain_fsm.sv
module drain_fsm
  import drain_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic fifo_empty,
  output logic rd_req,
  output logic wr_en,
  output logic rd_en,
  output logic step_addr,
  output logic bump_count
);
  drain_state_e state_q, state_n;

  always_comb begin
    state_n = state_q;
    case (state_q)
      ST_PARK:  if (!fifo_empty) state_n = ST_FETCH;
      ST_FETCH: state_n = ST_STORE;
      ST_STORE: state_n = fifo_empty ? ST_PARK : ST_FETCH;
      default:  state_n = ST_PARK;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_PARK;
    else     state_q <= state_n;
  end

  assign rd_req     = (state_q == ST_FETCH);
  assign wr_en      = (state_q == ST_STORE);
  assign rd_en      = (state_q == ST_STORE);
  assign step_addr  = (state_n == ST_FETCH);
  assign bump_count = (state_n == ST_STORE);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_PARK && fifo_empty) |=> (state_q == ST_PARK));

  // R4
  fetch_then_store_chk: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> (wr_en && rd_en && !rd_req));

  // R4
  single_req_chk: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> !rd_req);
endmodule

// File: rtl/drain_ptrs.sv
module drain_ptrs #(
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step_addr,
  input  logic              bump_count,
  output logic [ADDR_W-1:0] addr,
  output logic [CNT_W-1:0]  count
);
  localparam logic [ADDR_W-1:0] PARK_ADDR = '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr  <= PARK_ADDR;
      count <= '0;
    end else begin
      if (step_addr)  addr  <= addr + 1'b1;
      if (bump_count) count <= count + 1'b1;
    end
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (addr == PARK_ADDR && count == '0));
endmodule

// File: rtl/drain_ram.sv
module drain_ram #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (re) q <= we ? wdata : mem[addr];
  end

  // R7
  store_readback_chk: assert property (@(posedge clk) disable iff (rst)
    (we && re) |=> (q == $past(wdata)));
endmodule

// File: rtl/fifo_drain_ctrl.sv
module fifo_drain_ctrl #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fifo_empty,
  output logic              src_rd_req,
  input  logic [DATA_W-1:0] src_data,
  output logic [ADDR_W-1:0] st_addr,
  output logic [DATA_W-1:0] st_wdata,
  output logic              st_we,
  output logic              st_re,
  output logic [DATA_W-1:0] st_q,
  output logic [CNT_W-1:0]  xfer_count
);
  logic step_addr, bump_count;

  drain_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .fifo_empty (fifo_empty),
    .rd_req     (src_rd_req),
    .wr_en      (st_we),
    .rd_en      (st_re),
    .step_addr  (step_addr),
    .bump_count (bump_count)
  );

  drain_ptrs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ptrs (
    .clk        (clk),
    .rst        (rst),
    .step_addr  (step_addr),
    .bump_count (bump_count),
    .addr       (st_addr),
    .count      (xfer_count)
  );

  assign st_wdata = src_data;

  drain_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .clk   (clk),
    .rst   (rst),
    .we    (st_we),
    .re    (st_re),
    .addr  (st_addr),
    .wdata (st_wdata),
    .q     (st_q)
  );

  // R3
  fetch_addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    src_rd_req |-> (st_addr == ADDR_W'($past(st_addr) + 1'b1)));

  // R5
  store_addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    st_we |-> $stable(st_addr));

  // R6
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    st_we |-> (xfer_count == CNT_W'($past(xfer_count) + 1'b1)));

  // R8
  chain_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    (st_we && !fifo_empty) |=> src_rd_req);
endmodule

// File: tb/fifo_drain_ctrl_test.sv
module fifo_drain_ctrl_test;
  localparam int DW = 8;
  localparam int AW = 4;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fifo_empty;
  logic src_rd_req;
  logic [DW-1:0] src_data = '0;
  logic [AW-1:0] st_addr;
  logic [DW-1:0] st_wdata;
  logic st_we, st_re;
  logic [DW-1:0] st_q;
  logic [CW-1:0] xfer_count;

  int n_checks = 0;
  int n_fail = 0;

  // bench FIFO model: one cycle read latency
  logic [DW-1:0] fq [256];
  int wr_ptr = 0;
  int rd_ptr = 0;
  int exp_rd = 0;
  int exp_addr = 15;
  int exp_cnt = 0;

  always #10 clk = ~clk;

  assign fifo_empty = (wr_ptr == rd_ptr);

  always @(posedge clk) begin
    if (src_rd_req && !fifo_empty) begin
      src_data <= fq[rd_ptr & 255];
      rd_ptr   <= rd_ptr + 1;
    end
  end

  fifo_drain_ctrl #(.DATA_W(DW), .ADDR_W(AW), .CNT_W(CW)) uut (
    .clk(clk), .rst(rst), .fifo_empty(fifo_empty), .src_rd_req(src_rd_req),
    .src_data(src_data), .st_addr(st_addr), .st_wdata(st_wdata), .st_we(st_we),
    .st_re(st_re), .st_q(st_q), .xfer_count(xfer_count)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FIFO_DRAIN FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  task automatic push(input int n, input int base);
    for (int k = 0; k < n; k++) fq[(wr_ptr + k) & 255] = DW'(base + k);
    wr_ptr = wr_ptr + n;
  endtask

  // called at a negedge just after push; walks fetch/store pairs
  task automatic drain(input int n);
    logic [DW-1:0] prev;
    prev = '0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      exp_addr = (exp_addr + 1) & 15;
      chk("R3", "rd_req in fetch", int'(src_rd_req), 1);
      chk("R3", "addr in fetch", int'(st_addr), exp_addr);
      chk("R4", "we low in fetch", int'(st_we), 0);
      if (k > 0) chk("R7", "q after store", int'(st_q), int'(prev));
      @(negedge clk);
      exp_cnt = (exp_cnt + 1) & 255;
      prev = fq[exp_rd & 255];
      exp_rd++;
      chk("R4", "we in store", int'(st_we), 1);
      chk("R4", "re in store", int'(st_re), 1);
      chk("R4", "rd_req low in store", int'(src_rd_req), 0);
      chk("R5", "wdata in store", int'(st_wdata), int'(prev));
      chk("R5", "addr in store", int'(st_addr), exp_addr);
      chk("R6", "count in store", int'(xfer_count), exp_cnt);
    end
    @(negedge clk);
    chk("R7", "q after last store", int'(st_q), int'(prev));
    chk("R8", "no request once empty", int'(src_rd_req), 0);
    chk("R8", "no store once empty", int'(st_we), 0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R1", "addr parked", int'(st_addr), 15);
    chk("R1", "count", int'(xfer_count), 0);
    chk("R1", "q", int'(st_q), 0);
    chk("R1", "rd_req", int'(src_rd_req), 0);
    chk("R1", "we", int'(st_we), 0);
    chk("R1", "re", int'(st_re), 0);
    rst = 1'b0;
    exp_addr = 15;
    exp_cnt = 0;
  endtask

  task automatic t_idle_hold();
    int reqs = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (src_rd_req) reqs++;
    end
    chk("R2", "requests while empty", reqs, 0);
    chk("R2", "addr while empty", int'(st_addr), exp_addr);
  endtask

  task automatic t_single();
    push(1, 8'hA5);
    drain(1);
  endtask

  task automatic t_gap_keep();
    for (int i = 0; i < 4; i++) @(negedge clk);
    chk("R9", "addr kept over gap", int'(st_addr), exp_addr);
    push(1, 8'h3C);
    drain(1);
  endtask

  task automatic t_burst();
    push(4, 8'h10);
    drain(4);
  endtask

  task automatic t_wrap();
    // pointer now at 5; 13 words run it through 15 and back to 2
    push(13, 8'h40);
    drain(13);
    chk("R10", "addr after wrap", int'(st_addr), 2);
    chk("R10", "count after wrap", int'(xfer_count), 19);
  endtask

  task automatic t_rewind();
    t_reset();
    push(1, 8'hE7);
    drain(1);
    chk("R1", "first word after reset at zero", int'(st_addr), 0);
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FIFO_DRAIN FAIL watchdog: actual=timeout expected=done");
    report();
  end

  initial begin
    t_reset();
    t_idle_hold();
    t_single();
    t_gap_keep();
    t_burst();
    t_wrap();
    t_idle_hold();
    t_rewind();
    report();
  end
endmodule